// File: doc/BRIEF.md
# Double-Precision Funnel Shift Unit

This block shifts a 16-bit destination word by a count while filling the vacated positions from a second, source word, as a double-precision shift instruction of a processor does. A left shift brings the high bits of the source into the low end of the destination. A right shift brings the low bits of the source into the high end. Alongside the new destination word the unit produces the carry, overflow, sign, zero, auxiliary-carry and parity flags, plus a strobe that says whether the flags are to be written at all.

One request can be presented every clock cycle. The result, the flags and the flag-write strobe come out of an output register one cycle later, qualified by a response valid strobe. Counts from 17 to 31 have an exact, defined result: the destination word wraps back in behind the source, so the shifted stream reads destination, source, destination.

Top module: `fsh_unit`

## Requirements
- R1: Only the five least significant bits of `req_cnt` form the effective count; the upper bits of the count input have no effect on any output.
- R2: With an effective count of zero, `rsp_result` equals `req_dst`, `rsp_flag_we` is 0 and every flag output is 0, so the consumer keeps its prior flags.
- R3: Left shift (`req_dir` = 0) with count 1 to 16: the result is bits [31:16] of the 32-bit value {dst, src} shifted left by the count.
- R4: Left shift with count 17 to 31: the result is the upper 16 bits of {dst, src} shifted left by the count, ORed with dst shifted left by (count - 16), which is the upper word of the stream dst, src, dst shifted left by the count.
- R5: Right shift (`req_dir` = 1) with count 1 to 16: the result is bits [15:0] of {src, dst} shifted right by the count.
- R6: Right shift with count 17 to 31: the result is the lower 16 bits of {src, dst} shifted right by the count, ORed with dst shifted left by (32 - count).
- R7: Left-shift carry is bit (32 - count) of the unshifted pair {dst, src}, which is the last bit shifted out.
- R8: Right-shift carry is dst bit (count - 1) for counts up to 16 and src bit (count - 17) for counts above 16.
- R9: Overflow is carry XOR result bit 15 for a left shift, and result bit 15 XOR result bit 14 for a right shift.
- R10: For a nonzero count, sign is result bit 15, zero is set when the result is 0, and parity is set when the low 8 bits of the result hold an even number of ones.
- R11: For a nonzero count, `rsp_flag_we` is 1 and the auxiliary-carry flag `rsp_af` is 0.
- R12: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` high; a synchronous active-low reset clears `rsp_valid` and `rsp_flag_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_dir | input | 1 | 0 shifts left, 1 shifts right |
| req_dst | input | 16 | Destination word being shifted |
| req_src | input | 16 | Source word supplying fill bits |
| req_cnt | input | 8 | Shift count, only the low 5 bits are used |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_result | output | 16 | New destination word |
| rsp_flag_we | output | 1 | Flags are to be written (nonzero count) |
| rsp_cf | output | 1 | Carry flag |
| rsp_of | output | 1 | Overflow flag |
| rsp_sf | output | 1 | Sign flag |
| rsp_zf | output | 1 | Zero flag |
| rsp_af | output | 1 | Auxiliary-carry flag |
| rsp_pf | output | 1 | Parity flag |

## Verification
Every output of this unit is due exactly one rising edge after the edge that samples the request: the shifter, carry logic and flag logic are combinational and feed a single register stage. The bench drives each request on a falling edge, waits for the next rising edge, then compares one time unit later, so every compare reads the registered response to that request and no other. The same one-cycle relation is used for the strobes, where a cycle with no request is followed by a check that the response strobe and the flag-write strobe are low.

// File: rtl/fsh_pkg.sv
// Package: shared types of the funnel shift unit.
// Holds the flag bundle and the shift direction encoding.
package fsh_pkg;

    // Direction encoding as seen on req_dir.
    typedef enum logic {
        FSH_LEFT  = 1'b0,
        FSH_RIGHT = 1'b1
    } fsh_dir_e;

    // Flag bundle produced per operation.
    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
    } fsh_flags_t;

endpackage

// File: rtl/fsh_count_mask.sv
// Module: fsh_count_mask
// Reduces the raw count input to its effective low bits and flags whether
// the operation does anything. Assumes CIN_W >= CW.
module fsh_count_mask #(
    parameter int CIN_W = 8,
    parameter int CW    = 5
) (
    input  logic [CIN_W-1:0] cnt_raw,
    output logic [CW-1:0]    cnt_eff,
    output logic             cnt_nz
);

    // Keep only the low bits and detect a nonzero effective count.
    always_comb begin
        cnt_eff = cnt_raw[CW-1:0];
        cnt_nz  = |cnt_raw[CW-1:0];
    end

endmodule

// File: rtl/fsh_shift_core.sv
// Module: fsh_shift_core
// Combinational double-width shifter with carry and overflow generation.
// Left: {dst,src} shifted left, upper word kept; counts above W OR in dst
// shifted by (cnt-W). Right: {src,dst} shifted right, lower word kept;
// counts above W OR in dst shifted by (2W-cnt).
// Assumes 2**CW <= 2*W and W >= 2. Outputs for cnt == 0 are don't-care.
module fsh_shift_core
    import fsh_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  fsh_dir_e         dir,
    input  logic [W-1:0]     dst,
    input  logic [W-1:0]     src,
    input  logic [CW-1:0]    cnt,
    output logic [W-1:0]     res,
    output logic             cf,
    output logic             of
);

    localparam int DW = 2 * W;
    localparam int SW = $clog2(DW) + 1;
    localparam logic [SW-1:0] SW_W  = SW'(W);
    localparam logic [SW-1:0] SW_DW = SW'(DW);

    logic [SW-1:0] c;
    logic          over;
    logic [DW-1:0] dst_ext;
    logic [DW-1:0] pair_l, pair_r, shl, shr, cf_l_vec;
    logic [W-1:0]  cf_r_lo, cf_r_hi;
    logic          cf_l, cf_r;
    logic [W-1:0]  res_l, res_r;

    assign c       = SW'(cnt);
    assign over    = (c > SW_W);
    assign dst_ext = {{W{1'b0}}, dst};

    // Left funnel: shift the pair, wrap dst back in for long counts.
    always_comb begin
        pair_l = {dst, src};
        shl    = pair_l << c;
        if (over) begin
            shl = shl | (dst_ext << (c - SW_W));
        end
        res_l    = shl[DW-1:W];
        cf_l_vec = pair_l >> (SW_DW - c);
        cf_l     = cf_l_vec[0];
    end

    // Right funnel: shift the pair, wrap dst back in for long counts.
    always_comb begin
        pair_r = {src, dst};
        shr    = pair_r >> c;
        if (over) begin
            shr = shr | (dst_ext << (SW_DW - c));
        end
        res_r   = shr[W-1:0];
        cf_r_lo = dst >> (c - SW'(1));
        cf_r_hi = src >> (c - SW_W - SW'(1));
        cf_r    = over ? cf_r_hi[0] : cf_r_lo[0];
    end

    // Direction select and overflow rule per direction.
    always_comb begin
        if (dir == FSH_RIGHT) begin
            res = res_r;
            cf  = cf_r;
            of  = res_r[W-1] ^ res_r[W-2];
        end else begin
            res = res_l;
            cf  = cf_l;
            of  = cf_l ^ res_l[W-1];
        end
    end

endmodule

// File: rtl/fsh_flag_gen.sv
// Module: fsh_flag_gen
// Result-derived flags: sign, zero and even parity of the low byte.
// Assumes W >= 8.
module fsh_flag_gen #(
    parameter int W  = 16,
    parameter int PB = 8
) (
    input  logic [W-1:0] res,
    output logic         sf,
    output logic         zf,
    output logic         pf
);

    logic [PB-1:0] par_chain;

    // Ripple XOR over the parity byte, one stage per bit.
    generate
        for (genvar i = 0; i < PB; i++) begin : g_par
            if (i == 0) begin : g_first
                assign par_chain[i] = res[i];
            end else begin : g_next
                assign par_chain[i] = par_chain[i-1] ^ res[i];
            end
        end
    endgenerate

    // Sign from top bit, zero from whole word, parity set when even.
    always_comb begin
        sf = res[W-1];
        zf = (res == '0);
        pf = ~par_chain[PB-1];
    end

endmodule

// File: rtl/fsh_unit.sv
// Module: fsh_unit (top)
// Double-precision funnel shift unit with one register stage. A request
// presented with req_valid is answered one cycle later on rsp_*. A zero
// effective count returns dst unchanged with flags cleared and no write.
// Assumes the consumer holds its own flag state when rsp_flag_we is low.
module fsh_unit
    import fsh_pkg::*;
#(
    parameter int W     = 16,
    parameter int CIN_W = 8,
    parameter int CW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_dir,
    input  logic [W-1:0]     req_dst,
    input  logic [W-1:0]     req_src,
    input  logic [CIN_W-1:0] req_cnt,
    output logic             rsp_valid,
    output logic [W-1:0]     rsp_result,
    output logic             rsp_flag_we,
    output logic             rsp_cf,
    output logic             rsp_of,
    output logic             rsp_sf,
    output logic             rsp_zf,
    output logic             rsp_af,
    output logic             rsp_pf
);

    logic [CW-1:0] cnt_eff;
    logic          cnt_nz;
    logic [W-1:0]  sh_res;
    logic          sh_cf, sh_of;
    logic          fg_sf, fg_zf, fg_pf;
    logic [W-1:0]  nxt_res;
    fsh_flags_t    nxt_flags, q_flags;
    fsh_dir_e      dir;

    assign dir = fsh_dir_e'(req_dir);

    fsh_count_mask #(.CIN_W(CIN_W), .CW(CW)) u_mask (
        .cnt_raw (req_cnt),
        .cnt_eff (cnt_eff),
        .cnt_nz  (cnt_nz)
    );

    fsh_shift_core #(.W(W), .CW(CW)) u_core (
        .dir (dir),
        .dst (req_dst),
        .src (req_src),
        .cnt (cnt_eff),
        .res (sh_res),
        .cf  (sh_cf),
        .of  (sh_of)
    );

    fsh_flag_gen #(.W(W)) u_flags (
        .res (sh_res),
        .sf  (fg_sf),
        .zf  (fg_zf),
        .pf  (fg_pf)
    );

    // Choose pass-through or shifted result and assemble the flag bundle.
    always_comb begin
        if (cnt_nz) begin
            nxt_res      = sh_res;
            nxt_flags.cf = sh_cf;
            nxt_flags.of = sh_of;
            nxt_flags.sf = fg_sf;
            nxt_flags.zf = fg_zf;
            nxt_flags.af = 1'b0;
            nxt_flags.pf = fg_pf;
        end else begin
            nxt_res   = req_dst;
            nxt_flags = '0;
        end
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_flag_we <= 1'b0;
            rsp_result  <= '0;
            q_flags     <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_flag_we <= req_valid & cnt_nz;
            if (req_valid) begin
                rsp_result <= nxt_res;
                q_flags    <= nxt_flags;
            end
        end
    end

    assign rsp_cf = q_flags.cf;
    assign rsp_of = q_flags.of;
    assign rsp_sf = q_flags.sf;
    assign rsp_zf = q_flags.zf;
    assign rsp_af = q_flags.af;
    assign rsp_pf = q_flags.pf;

endmodule

// File: rtl/fsh_unit_chk.sv
// Module: fsh_unit_chk
// Temporal checks on the ports of fsh_unit, attached by bind below.
module fsh_unit_chk #(
    parameter int W     = 16,
    parameter int CIN_W = 8,
    parameter int CW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_dir,
    input logic [W-1:0]     req_dst,
    input logic [CIN_W-1:0] req_cnt,
    input logic             rsp_valid,
    input logic [W-1:0]     rsp_result,
    input logic             rsp_flag_we,
    input logic             rsp_cf,
    input logic             rsp_of,
    input logic             rsp_zf,
    input logic             rsp_af
);

    // Response strobe follows the request strobe by one cycle.
    assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_valid)));

    // Flag write only with a response and never with AF set.
    assert_flag_we_af_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_flag_we |-> (rsp_valid && !rsp_af));

    // Flag write tracks the low count bits of the answered request.
    assert_count_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_flag_we == ($past(req_cnt[CW-1:0]) != '0)));

    // Zero count returns the destination word untouched.
    assert_zero_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_flag_we) |-> (rsp_result == $past(req_dst)));

    // Zero flag agrees with the registered result.
    assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_flag_we |-> (rsp_zf == (rsp_result == '0)));

    // Left-shift overflow rule.
    assert_left_of_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_flag_we && !$past(req_dir)) |-> (rsp_of == (rsp_cf ^ rsp_result[W-1])));

endmodule

bind fsh_unit fsh_unit_chk #(.W(W), .CIN_W(CIN_W), .CW(CW)) u_fsh_unit_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_dir     (req_dir),
    .req_dst     (req_dst),
    .req_cnt     (req_cnt),
    .rsp_valid   (rsp_valid),
    .rsp_result  (rsp_result),
    .rsp_flag_we (rsp_flag_we),
    .rsp_cf      (rsp_cf),
    .rsp_of      (rsp_of),
    .rsp_zf      (rsp_zf),
    .rsp_af      (rsp_af)
);

// File: tb/fsh_unit_bench.sv
`timescale 1ns/1ps
// Bench: sweeps every count in both directions over several operand
// patterns; expected values come from a 48-bit dst:src:dst stream model.
module fsh_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_dir = 1'b0;
    logic [15:0] req_dst = '0;
    logic [15:0] req_src = '0;
    logic [7:0]  req_cnt = '0;
    logic        rsp_valid, rsp_flag_we;
    logic [15:0] rsp_result;
    logic        rsp_cf, rsp_of, rsp_sf, rsp_zf, rsp_af, rsp_pf;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fsh_unit u_fsh_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
        .req_dst(req_dst), .req_src(req_src), .req_cnt(req_cnt),
        .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_flag_we(rsp_flag_we),
        .rsp_cf(rsp_cf), .rsp_of(rsp_of), .rsp_sf(rsp_sf), .rsp_zf(rsp_zf),
        .rsp_af(rsp_af), .rsp_pf(rsp_pf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request, then compare every output against the stream model.
    task automatic run_op(input logic dir, input logic [15:0] d, input logic [15:0] s,
                          input logic [7:0] cnt_in, input bit tag_mask);
        int c;
        logic [47:0] strm, sh;
        logic [15:0] e_res;
        logic e_cf, e_of;
        string rtag;
        c = int'(cnt_in[4:0]);
        strm = {d, s, d};
        @(negedge clk);
        req_valid = 1'b1; req_dir = dir; req_dst = d; req_src = s; req_cnt = cnt_in;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk("R12 valid", 32'(rsp_valid), 32'd1);
        if (c == 0) begin
            chk("R2 result", 32'(rsp_result), 32'(d));
            chk("R2 flag_we", 32'(rsp_flag_we), 32'd0);
            chk("R2 flags", 32'({rsp_cf, rsp_of, rsp_sf, rsp_zf, rsp_af, rsp_pf}), 32'd0);
            return;
        end
        if (!dir) begin
            sh    = strm << c;
            e_res = sh[47:32];
            e_cf  = strm[48 - c];
            e_of  = e_cf ^ e_res[15];
            rtag  = (c > 16) ? "R4 left result" : "R3 left result";
            chk("R7 left carry", 32'(rsp_cf), 32'(e_cf));
        end else begin
            sh    = strm >> c;
            e_res = sh[15:0];
            e_cf  = strm[c - 1];
            e_of  = e_res[15] ^ e_res[14];
            rtag  = (c > 16) ? "R6 right result" : "R5 right result";
            chk("R8 right carry", 32'(rsp_cf), 32'(e_cf));
        end
        if (tag_mask) rtag = "R1 masked count result";
        chk(rtag, 32'(rsp_result), 32'(e_res));
        chk("R9 overflow", 32'(rsp_of), 32'(e_of));
        chk("R10 sign/zero/parity", 32'({rsp_sf, rsp_zf, rsp_pf}),
            32'({e_res[15], (e_res == 16'h0), ~(^e_res[7:0])}));
        chk("R11 af/flag_we", 32'({rsp_af, rsp_flag_we}), 32'b01);
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] pd[5];
        logic [15:0] ps[5];
        pd[0] = 16'hA5C3; ps[0] = 16'h3C96;
        pd[1] = 16'h8001; ps[1] = 16'h0000;
        pd[2] = 16'h0000; ps[2] = 16'hFFFF;
        pd[3] = 16'h1234; ps[3] = 16'hFEDC;
        pd[4] = 16'h0000; ps[4] = 16'h0000;
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        chk("R12 reset valid", 32'(rsp_valid), 32'd0);
        chk("R12 reset flag_we", 32'(rsp_flag_we), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < 5; p++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int c = 0; c < 32; c++) begin
                    run_op(dir[0], pd[p], ps[p], 8'(c), 1'b0);
                end
            end
        end
        // R1: upper count bits ignored
        for (int dir = 0; dir < 2; dir++) begin
            for (int c = 0; c < 32; c++) begin
                run_op(dir[0], pd[0], ps[0], 8'(c) | 8'hE0, 1'b1);
                run_op(dir[0], pd[3], ps[3], 8'(c) | 8'h20, 1'b1);
            end
        end
        // R12: idle cycle gives no response and no flag write
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R12 idle valid", 32'(rsp_valid), 32'd0);
        chk("R12 idle flag_we", 32'(rsp_flag_we), 32'd0);
        // R12: reset in mid-stream clears the strobes
        @(negedge clk);
        req_valid = 1'b1; req_cnt = 8'd3;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R12 reset clears valid", 32'(rsp_valid), 32'd0);
        chk("R12 reset clears flag_we", 32'(rsp_flag_we), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule